// File: doc/BRIEF.md
# Frame Buffer DMA Fetch Engine

This block reads a frame of pixel words out of memory for a display controller and hands them to a downstream pixel FIFO. Software programs one or two frame regions. Each region is a base address and an inclusive ceiling address, both as byte addresses. The engine walks a region word by word in bursts, using a request/response memory read port. Each returned word goes straight into the FIFO. A burst is issued only when the FIFO has room for the whole burst.

When the engine reaches the ceiling it marks the frame done with a per-region end-of-frame flag. In single-region mode it then restarts at the same base. In two-region mode it alternates between the regions.

Software changes to a base or ceiling register take effect only at the next frame start. Two extra status flags record a pixel-FIFO underflow and a loss of display sync, both reported by the downstream timing logic. An interrupt line combines the enabled end-of-frame flags with those two error flags.

Top module: `fbf_dma`

## Requirements
- R1: After reset, `rd_req`, `fifo_push` and `irq` are low, and every register reads back 0.
- R2: Registers are selected by `reg_addr`: 0 control, 1 status, 2 base of region 0, 3 ceiling of region 0, 4 base of region 1, 5 ceiling of region 1. Control bits are: bit 0 two-region mode, bit 2 end-of-frame interrupt enable, bit 3 run, bits 6:4 burst code. Unused control bits read as 0.
- R3: Burst codes 0 to 4 allow bursts of 1, 2, 4, 8 and 16 words. Codes 5 to 7 are invalid, and with an invalid code no read request is made.
- R4: Requests walk the region in rising addresses, with a step of 4 bytes per word. Each returned word is pushed to the FIFO unchanged and in order.
- R5: The last burst of a frame is shortened so that its last byte does not go past the inclusive ceiling.
- R6: In single-region mode, finishing the ceiling burst sets status bit 8, and the next frame starts again at the base of region 0.
- R7: In two-region mode, frames alternate region 0, region 1, region 0, and so on, starting with region 0. Finishing a region sets status bit 8 for region 0 or status bit 9 for region 1.
- R8: Writing 1 to a status bit (2, 5, 8 or 9) clears it. Writing 0 leaves it unchanged. A flag being set in the same cycle wins over the clear.
- R9: A pulse on `pix_underflow` sets status bit 5, and a pulse on `sync_lost` sets status bit 2. Both flags stay set until cleared.
- R10: `irq` is high when (status bit 8 or 9 is set and control bit 2 is set), or when status bit 5 or status bit 2 is set.
- R11: Clearing the run bit lets a burst already in flight finish in full, and no further request is made. A later restart begins at the base of region 0.
- R12: A base or ceiling written during a frame is used only from the next frame start.
- R13: A request holds its address and length until `rd_ready` accepts it. A burst is only requested when `fifo_room` is at least its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Interrupt request |
| rd_req | output | 1 | Burst read request valid |
| rd_addr | output | ADDR_W | Byte address of the first word of the burst |
| rd_len | output | LEN_W | Burst length in words |
| rd_ready | input | 1 | Memory accepts the request |
| rd_valid | input | 1 | Read data word valid |
| rd_data | input | DATA_W | Read data word |
| fifo_push | output | 1 | Write strobe into the pixel FIFO |
| fifo_wdata | output | DATA_W | Word written into the pixel FIFO |
| fifo_room | input | ROOM_W | Free entries in the pixel FIFO |
| pix_underflow | input | 1 | Pixel FIFO underflow pulse |
| sync_lost | input | 1 | Display sync lost pulse |

## Verification
Four properties are checked on every cycle:
- a stalled request stays stable;
- no request reaches past the ceiling latched for the frame in progress;
- each end-of-frame flag rises only right after a FIFO push;
- an underflow pulse always leaves its status flag set.

The remaining behaviours are shown only by the directed scenarios. These are the address order, region alternation, reload at the base, write-one-to-clear, the interrupt mask, stop-after-burst, delayed use of new region values, invalid burst codes and the FIFO-room gate.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_DATA} fetch_state_t;

   localparam int NREGION       = 2;
   localparam int CTL_DUAL_BIT  = 0;
   localparam int CTL_IE_BIT    = 2;
   localparam int CTL_RUN_BIT   = 3;
   localparam int CTL_CODE_LSB  = 4;
   localparam int ST_SYNC_BIT   = 2;
   localparam int ST_UDF_BIT    = 5;
   localparam int ST_EOF_LSB    = 8;

   localparam logic [2:0] SEL_CTRL  = 3'd0;
   localparam logic [2:0] SEL_STAT  = 3'd1;
   localparam logic [2:0] SEL_BASE0 = 3'd2;
endpackage

// File: rtl/fbf_regs.sv
module fbf_regs
   import fbf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_wr,
   input  logic [2:0]                        reg_addr,
   input  logic [31:0]                       reg_wdata,
   output logic [31:0]                       reg_rdata,
   input  logic [NREGION-1:0]                eof_set,
   input  logic                              udf_in,
   input  logic                              sync_in,
   output logic                              dual_en,
   output logic                              run_en,
   output logic [2:0]                        burst_code,
   output logic [NREGION-1:0][ADDR_W-1:0]    base_o,
   output logic [NREGION-1:0][ADDR_W-1:0]    ceil_o,
   output logic [NREGION-1:0]                eof_flags,
   output logic                              udf_flag,
   output logic                              sync_flag,
   output logic                              irq
);
   logic ie_en;
   logic wr_ctrl, wr_stat;

   assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
   assign wr_stat = reg_wr && (reg_addr == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dual_en    <= 1'b0;
         ie_en      <= 1'b0;
         run_en     <= 1'b0;
         burst_code <= '0;
      end else if (wr_ctrl) begin
         dual_en    <= reg_wdata[CTL_DUAL_BIT];
         ie_en      <= reg_wdata[CTL_IE_BIT];
         run_en     <= reg_wdata[CTL_RUN_BIT];
         burst_code <= reg_wdata[CTL_CODE_LSB +: 3];
      end
   end

   for (genvar g = 0; g < NREGION; g++) begin : g_region
      localparam logic [2:0] SEL_B = SEL_BASE0 + 3'(2 * g);
      localparam logic [2:0] SEL_C = SEL_BASE0 + 3'(2 * g + 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            ceil_o[g] <= '0;
         end else if (reg_wr) begin
            if (reg_addr == SEL_B) base_o[g] <= reg_wdata[ADDR_W-1:0];
            if (reg_addr == SEL_C) ceil_o[g] <= reg_wdata[ADDR_W-1:0];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   eof_flags[g] <= 1'b0;
         else if (eof_set[g])                          eof_flags[g] <= 1'b1;
         else if (wr_stat && reg_wdata[ST_EOF_LSB+g])  eof_flags[g] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         udf_flag  <= 1'b0;
         sync_flag <= 1'b0;
      end else begin
         if (udf_in)                               udf_flag  <= 1'b1;
         else if (wr_stat && reg_wdata[ST_UDF_BIT])  udf_flag  <= 1'b0;
         if (sync_in)                              sync_flag <= 1'b1;
         else if (wr_stat && reg_wdata[ST_SYNC_BIT]) sync_flag <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_CTRL: begin
            reg_rdata[CTL_DUAL_BIT]        = dual_en;
            reg_rdata[CTL_IE_BIT]          = ie_en;
            reg_rdata[CTL_RUN_BIT]         = run_en;
            reg_rdata[CTL_CODE_LSB +: 3]   = burst_code;
         end
         SEL_STAT: begin
            reg_rdata[ST_SYNC_BIT]               = sync_flag;
            reg_rdata[ST_UDF_BIT]                = udf_flag;
            reg_rdata[ST_EOF_LSB +: NREGION]     = eof_flags;
         end
         default: begin
            for (int k = 0; k < NREGION; k++) begin
               if (reg_addr == SEL_BASE0 + 3'(2 * k))     reg_rdata[ADDR_W-1:0] = base_o[k];
               if (reg_addr == SEL_BASE0 + 3'(2 * k + 1)) reg_rdata[ADDR_W-1:0] = ceil_o[k];
            end
         end
      endcase
   end

   assign irq = ((|eof_flags) && ie_en) || udf_flag || sync_flag;
endmodule

// File: rtl/fbf_burst_calc.sv
module fbf_burst_calc #(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 5,
   parameter int SHIFT    = 2,
   parameter int MAX_CODE = 4
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ADDR_W-1:0] ceil_addr,
   input  logic [2:0]        code,
   output logic              code_ok,
   output logic [LEN_W-1:0]  len,
   output logic              last
);
   logic [ADDR_W-1:0] words_left;
   logic [ADDR_W-1:0] max_len;

   always_comb begin
      code_ok = (int'(code) <= MAX_CODE);
      max_len = code_ok ? (ADDR_W'(1) << code) : ADDR_W'(1);
      if (cur_addr > ceil_addr) words_left = ADDR_W'(1);
      else                      words_left = ((ceil_addr - cur_addr) >> SHIFT) + ADDR_W'(1);
      if (words_left <= max_len) begin
         len  = words_left[LEN_W-1:0];
         last = 1'b1;
      end else begin
         len  = max_len[LEN_W-1:0];
         last = 1'b0;
      end
   end
endmodule

// File: rtl/fbf_fetch_fsm.sv
module fbf_fetch_fsm
   import fbf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5,
   parameter int ROOM_W = 6,
   parameter int SHIFT  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           run_en,
   input  logic                           dual_en,
   input  logic                           code_ok,
   input  logic [LEN_W-1:0]               len_calc,
   input  logic                           last_calc,
   input  logic [NREGION-1:0][ADDR_W-1:0] base_i,
   input  logic [NREGION-1:0][ADDR_W-1:0] ceil_i,
   input  logic [ROOM_W-1:0]              fifo_room,
   output logic [ADDR_W-1:0]              cur_addr,
   output logic [ADDR_W-1:0]              frm_ceil,
   output logic                           rd_req,
   output logic [ADDR_W-1:0]              rd_addr,
   output logic [LEN_W-1:0]               rd_len,
   input  logic                           rd_ready,
   input  logic                           rd_valid,
   input  logic [DATA_W-1:0]              rd_data,
   output logic                           fifo_push,
   output logic [DATA_W-1:0]              fifo_wdata,
   output logic [NREGION-1:0]             eof_set
);
   localparam int CW = ROOM_W + LEN_W;

   fetch_state_t state;
   logic             frame_open;
   logic             sel;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt;
   logic             last_q;
   logic             room_ok;
   logic             burst_done;

   assign room_ok    = CW'(fifo_room) >= CW'(len_calc);
   assign burst_done = (state == FS_DATA) && rd_valid && (cnt == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= FS_IDLE;
         frame_open <= 1'b0;
         sel        <= 1'b0;
         cur_addr   <= '0;
         frm_ceil   <= '0;
         len_q      <= '0;
         cnt        <= '0;
         last_q     <= 1'b0;
      end else begin
         case (state)
            FS_IDLE: begin
               if (!frame_open) begin
                  if (run_en && code_ok) begin
                     frame_open <= 1'b1;
                     cur_addr   <= base_i[sel];
                     frm_ceil   <= ceil_i[sel];
                  end else if (!run_en) begin
                     sel <= 1'b0;
                  end
               end else if (!run_en) begin
                  frame_open <= 1'b0;
                  sel        <= 1'b0;
               end else if (code_ok && room_ok) begin
                  len_q  <= len_calc;
                  last_q <= last_calc;
                  state  <= FS_REQ;
               end
            end
            FS_REQ: begin
               if (rd_ready) begin
                  cnt   <= len_q;
                  state <= FS_DATA;
               end
            end
            FS_DATA: begin
               if (rd_valid) begin
                  cnt <= cnt - LEN_W'(1);
                  if (burst_done) begin
                     cur_addr <= cur_addr + (ADDR_W'(len_q) << SHIFT);
                     state    <= FS_IDLE;
                     if (last_q) begin
                        frame_open <= 1'b0;
                        sel        <= dual_en ? ~sel : 1'b0;
                     end
                  end
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   assign rd_req     = (state == FS_REQ);
   assign rd_addr    = cur_addr;
   assign rd_len     = len_q;
   assign fifo_push  = (state == FS_DATA) && rd_valid;
   assign fifo_wdata = rd_data;

   always_comb begin
      eof_set = '0;
      if (burst_done && last_q) eof_set[sel] = 1'b1;
   end
endmodule

// File: rtl/fbf_dma.sv
module fbf_dma
   import fbf_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int MAX_BURST = 16,
   parameter int ROOM_W    = 6,
   localparam int LEN_W    = $clog2(MAX_BURST) + 1,
   localparam int MAX_CODE = $clog2(MAX_BURST),
   localparam int SHIFT    = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LEN_W-1:0]  rd_len,
   input  logic              rd_ready,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_wdata,
   input  logic [ROOM_W-1:0] fifo_room,
   input  logic              pix_underflow,
   input  logic              sync_lost
);
   if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
      $error("fbf_dma: ADDR_W must lie in 8..32");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("fbf_dma: DATA_W must be a power of two of at least 8");
   end
   if ((MAX_BURST & (MAX_BURST - 1)) != 0 || MAX_BURST > 128) begin : g_bad_burst
      $error("fbf_dma: MAX_BURST must be a power of two up to 128");
   end
   if ((2 ** ROOM_W) - 1 < MAX_BURST) begin : g_bad_room
      $error("fbf_dma: ROOM_W too narrow for MAX_BURST");
   end

   logic                           dual_en, run_en;
   logic [2:0]                     burst_code;
   logic [NREGION-1:0][ADDR_W-1:0] base_v, ceil_v;
   logic [NREGION-1:0]             eof_flags, eof_set;
   logic                           udf_flag, sync_flag;
   logic [ADDR_W-1:0]              cur_addr, frm_ceil;
   logic                           code_ok, last_calc;
   logic [LEN_W-1:0]               len_calc;

   fbf_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eof_set(eof_set),
      .udf_in(pix_underflow), .sync_in(sync_lost), .dual_en(dual_en),
      .run_en(run_en), .burst_code(burst_code), .base_o(base_v),
      .ceil_o(ceil_v), .eof_flags(eof_flags), .udf_flag(udf_flag),
      .sync_flag(sync_flag), .irq(irq)
   );

   fbf_burst_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SHIFT(SHIFT), .MAX_CODE(MAX_CODE)) calc_i (
      .cur_addr(cur_addr), .ceil_addr(frm_ceil), .code(burst_code),
      .code_ok(code_ok), .len(len_calc), .last(last_calc)
   );

   fbf_fetch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                   .ROOM_W(ROOM_W), .SHIFT(SHIFT)) fsm_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .dual_en(dual_en),
      .code_ok(code_ok), .len_calc(len_calc), .last_calc(last_calc),
      .base_i(base_v), .ceil_i(ceil_v), .fifo_room(fifo_room),
      .cur_addr(cur_addr), .frm_ceil(frm_ceil), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_len(rd_len), .rd_ready(rd_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .fifo_push(fifo_push),
      .fifo_wdata(fifo_wdata), .eof_set(eof_set)
   );
endmodule

// File: rtl/fbf_dma_chk.sv
module fbf_dma_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 5,
   parameter int SHIFT  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_ready,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [LEN_W-1:0]  rd_len,
   input logic              fifo_push,
   input logic [ADDR_W-1:0] frm_ceil,
   input logic [1:0]        eof_flags,
   input logic              pix_underflow,
   input logic              udf_flag
);
   logic [ADDR_W:0] last_byte;
   assign last_byte = {1'b0, rd_addr} + ((ADDR_W+1)'(rd_len) << SHIFT) - (ADDR_W+1)'(1);

   assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr) && $stable(rd_len)));

   assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (last_byte <= {1'b0, frm_ceil}));

   assert_eof0_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eof_flags[0]) |-> $past(fifo_push));

   assert_eof1_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eof_flags[1]) |-> $past(fifo_push));

   assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_underflow |=> udf_flag);
endmodule

bind fbf_dma fbf_dma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SHIFT(SHIFT)) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ready(rd_ready),
   .rd_addr(rd_addr), .rd_len(rd_len), .fifo_push(fifo_push),
   .frm_ceil(frm_ceil), .eof_flags(eof_flags),
   .pix_underflow(pix_underflow), .udf_flag(udf_flag)
);

// File: tb/fbf_dma_tb_top.sv
`timescale 1ns/100ps
module fbf_dma_tb_top;
   localparam int AW = 32, DW = 32, LW = 5, RW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic [LW-1:0] rd_len;
   logic          rd_ready = 1'b1;
   logic          rd_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          fifo_push;
   logic [DW-1:0] fifo_wdata;
   logic [RW-1:0] fifo_room = RW'(32);
   logic          pix_underflow = 1'b0;
   logic          sync_lost = 1'b0;

   fbf_dma dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_room(fifo_room),
      .pix_underflow(pix_underflow), .sync_lost(sync_lost)
   );

   initial forever #2.5 clk = ~clk;

   int n_tests = 0, n_fail = 0;
   logic ready_ctl = 1'b1;
   logic [31:0] req_addr_log [64];
   int          req_len_log  [64];
   logic [31:0] word_log     [512];
   int nreq = 0, nword = 0;

   // memory model and monitor: drives after each falling edge, logs what the next rising edge consumes
   initial begin
      int mcnt = 0;
      logic [31:0] maddr = '0;
      forever begin
         @(negedge clk);
         rd_ready = ready_ctl;
         if (mcnt > 0) begin
            rd_valid = 1'b1; rd_data = maddr; maddr += 4; mcnt--;
         end else begin
            rd_valid = 1'b0;
         end
         #1;
         if (fifo_push && nword < 512) begin word_log[nword] = fifo_wdata; nword++; end
         if (mcnt == 0 && !rd_valid && rd_req && rd_ready) begin
            mcnt = int'(rd_len); maddr = rd_addr;
            if (nreq < 64) begin req_addr_log[nreq] = rd_addr; req_len_log[nreq] = int'(rd_len); end
            nreq++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_tests++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_req(input int n);
      for (int k = 0; k < 600 && nreq < n; k++) @(negedge clk);
   endtask

   task automatic stop_drain();
      wr(3'd0, 32'h0);
      repeat (40) @(negedge clk);
      wr(3'd1, 32'h324);
      nreq = 0; nword = 0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      #1;
      chk(!rd_req && !fifo_push && !irq, "R1 outputs idle", {rd_req, fifo_push, irq}, 0);
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk(v == 0, "R1 register reset", v, 0);
      end
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(3'd0, 32'hFFFF_FFF7);
      rd(3'd0, v);  chk(v == 32'h75, "R2 ctrl readback", v, 32'h75);
      wr(3'd4, 32'hDEAD_BEE0);
      rd(3'd4, v);  chk(v == 32'hDEAD_BEE0, "R2 base1 readback", v, 32'hDEAD_BEE0);
      wr(3'd0, 32'h0); wr(3'd4, 32'h0);
      chk(nreq == 0, "R2 no fetch without run", nreq, 0);
   endtask

   task automatic t_single();
      logic [31:0] v; bit ok = 1;
      wr(3'd2, 32'h100); wr(3'd3, 32'h13F);
      wr(3'd0, 32'h28);
      wait_req(5);
      for (int i = 0; i < 4; i++)
         if (req_addr_log[i] != 32'h100 + 32'(16*i) || req_len_log[i] != 4) ok = 0;
      chk(ok, "R3 R4 four bursts of 4 words", req_addr_log[3], 32'h130);
      chk(req_addr_log[4] == 32'h100, "R6 reload base0", req_addr_log[4], 32'h100);
      ok = 1;
      for (int i = 0; i < 16; i++) if (word_log[i] != 32'h100 + 32'(4*i)) ok = 0;
      chk(ok && nword >= 16, "R4 pushed words in order", word_log[15], 32'h13C);
      rd(3'd1, v); chk(v == 32'h100, "R6 eof0 flag", v, 32'h100);
      stop_drain();
   endtask

   task automatic t_trunc();
      wr(3'd2, 32'h200); wr(3'd3, 32'h217);
      wr(3'd0, 32'h28);
      wait_req(3);
      chk(req_len_log[0] == 4 && req_len_log[1] == 2, "R5 short last burst", req_len_log[1], 2);
      chk(req_addr_log[1] == 32'h210 && req_addr_log[2] == 32'h200, "R5 R6 tail then reload", req_addr_log[1], 32'h210);
      stop_drain();
   endtask

   task automatic t_dual_w1c();
      logic [31:0] v;
      wr(3'd2, 32'h100); wr(3'd3, 32'h10F);
      wr(3'd4, 32'h400); wr(3'd5, 32'h40F);
      wr(3'd0, 32'h49);
      wait_req(3);
      chk(req_addr_log[0] == 32'h100 && req_len_log[0] == 4, "R7 first region 0", req_addr_log[0], 32'h100);
      chk(req_addr_log[1] == 32'h400, "R7 then region 1", req_addr_log[1], 32'h400);
      chk(req_addr_log[2] == 32'h100, "R7 back to region 0", req_addr_log[2], 32'h100);
      wr(3'd0, 32'h0); repeat (40) @(negedge clk);
      rd(3'd1, v); chk(v == 32'h300, "R7 both eof flags", v, 32'h300);
      wr(3'd1, 32'h100);
      rd(3'd1, v); chk(v == 32'h200, "R8 clear eof0 only", v, 32'h200);
      wr(3'd1, 32'h0);
      rd(3'd1, v); chk(v == 32'h200, "R8 write zero no effect", v, 32'h200);
      wr(3'd1, 32'h200);
      rd(3'd1, v); chk(v == 32'h0, "R8 clear eof1", v, 0);
      stop_drain();
   endtask

   task automatic t_irq();
      wr(3'd2, 32'h100); wr(3'd3, 32'h103);
      wr(3'd0, 32'h2C);
      wait_req(1); repeat (10) @(negedge clk);
      wr(3'd0, 32'h04); repeat (10) @(negedge clk);
      #1; chk(irq == 1'b1, "R10 irq on enabled eof", irq, 1);
      wr(3'd0, 32'h00); #1;
      chk(irq == 1'b0, "R10 irq masked", irq, 0);
      stop_drain();
      @(negedge clk); pix_underflow = 1'b1; @(negedge clk); pix_underflow = 1'b0;
      #1; chk(irq == 1'b1, "R10 irq on underflow", irq, 1);
   endtask

   task automatic t_errflags();
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rd(3'd1, v); chk(v == 32'h20, "R9 underflow sticky", v, 32'h20);
      @(negedge clk); sync_lost = 1'b1; @(negedge clk); sync_lost = 1'b0;
      rd(3'd1, v); chk(v == 32'h24, "R9 sync lost flag", v, 32'h24);
      wr(3'd1, 32'h24);
      rd(3'd1, v); chk(v == 32'h0, "R8 clear error flags", v, 0);
      #1; chk(irq == 1'b0, "R10 irq low when clear", irq, 0);
   endtask

   task automatic t_stop();
      wr(3'd2, 32'h1000); wr(3'd3, 32'h1FFF);
      wr(3'd0, 32'h48);
      wait_req(2);
      wr(3'd0, 32'h0);
      repeat (40) @(negedge clk);
      chk(nreq == 2, "R11 no request after stop", nreq, 2);
      chk(nword == 32, "R11 burst in flight completes", nword, 32);
      nreq = 0; nword = 0;
      wr(3'd0, 32'h48);
      wait_req(1);
      chk(req_addr_log[0] == 32'h1000, "R11 restart at base", req_addr_log[0], 32'h1000);
      stop_drain();
   endtask

   task automatic t_shadow();
      wr(3'd2, 32'h100); wr(3'd3, 32'h13F);
      wr(3'd0, 32'h28);
      wait_req(2);
      wr(3'd2, 32'h120);
      wait_req(6);
      chk(req_addr_log[2] == 32'h120 && req_addr_log[3] == 32'h130, "R12 frame keeps old region", req_addr_log[3], 32'h130);
      chk(req_addr_log[4] == 32'h120, "R12 new base next frame", req_addr_log[4], 32'h120);
      stop_drain();
   endtask

   task automatic t_invalid();
      wr(3'd2, 32'h100); wr(3'd3, 32'h13F);
      wr(3'd0, 32'h58);
      repeat (30) @(negedge clk);
      chk(nreq == 0 && !rd_req, "R3 invalid code blocks fetch", nreq, 0);
      stop_drain();
   endtask

   task automatic t_room_hold();
      logic [31:0] a0;
      fifo_room = RW'(3);
      wr(3'd0, 32'h28);
      repeat (20) @(negedge clk);
      chk(nreq == 0 && !rd_req, "R13 no burst without room", nreq, 0);
      ready_ctl = 1'b0;
      fifo_room = RW'(4);
      repeat (6) @(negedge clk); #1;
      a0 = rd_addr;
      chk(rd_req && a0 == 32'h100 && rd_len == 4, "R13 request raised", a0, 32'h100);
      repeat (5) @(negedge clk); #1;
      chk(rd_req && rd_addr == a0 && rd_len == 4, "R13 request held stable", rd_addr, a0);
      ready_ctl = 1'b1;
      wait_req(1);
      chk(nreq >= 1 && req_addr_log[0] == 32'h100, "R13 accepted after ready", req_addr_log[0], 32'h100);
      fifo_room = RW'(32);
      stop_drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_regs();
      t_single();
      t_trunc();
      t_dual_w1c();
      t_irq();
      t_errflags();
      t_stop();
      t_shadow();
      t_invalid();
      t_room_hold();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule